// File: doc/BRIEF.md
# Mixed-Signal Boundary-Scan Test Controller

This block is the complete digital side of a small mixed-signal boundary-scan device whose core holds one analog follower path and one logic inverter. A serial test port (clock, mode select, serial in, serial out, asynchronous reset) walks a sixteen-state test-access state machine. That machine loads an eight-bit instruction and then either shifts a one-bit bypass stage or a fourteen-bit boundary-scan chain.

The chain holds a four-bit word for the interface between the two external analog test pins and the two internal analog buses. It also holds one four-bit control word for each analog pin cell, plus one digital input cell and one digital output cell. Each word is latched on update and decoded into switch enables. For every analog pin cell these are six enables: core, high reference, low reference, ground reference, bus 1 and bus 2. For the bus interface they are four enables. The decode depends on which mode the current instruction selects: mission, isolating test or probing test.

The analog switches, comparators and reference sources sit outside this block. Only their digital enables leave it, and only one comparator result per analog pin cell comes back in.

Top module: `mxbs_ctrl`

## Requirements
- R1: The controller follows the standard sixteen-state test-access state graph on rising `tck`. Pause and exit states do not disturb shifted data. Five consecutive cycles with `tms`=1 reach Test-Logic-Reset from any state.
- R2: Asserting `trst_n` low, or one clock spent in Test-Logic-Reset, has three effects: the instruction becomes BYPASS (0xFF), every update latch becomes 0, and mission mode applies.
- R3: Capture-IR loads 0x01 into the instruction shift stage. Instruction bits shift in and out least significant bit first. A new instruction takes effect on the clock that leaves Update-IR.
- R4: Opcode 0x00 selects isolating test, 0x01 selects probing test and 0x02 selects sample/preload. These three choose the boundary-scan chain. Every other opcode, 0xFF included, behaves as BYPASS: the one-bit stage captures 0 and delays serial in by one clock. `abm_mode` reads 0 for mission, 1 for isolating test and 2 for probing test, and never reads 3.
- R5: The chain is 14 bits long; bit 0 is nearest `tdo`. Bit 0 is the digital output cell and bit 1 the digital input cell. Bits 5..2 hold the control word of analog cell 0 (the output pin) and bits 9..6 that of analog cell 1 (the input pin). Bits 13..10 hold the bus-interface word. Within an analog word the upper bit is D, then C, B1 and B2, so data moves serial in -> D -> C -> B1 -> B2 -> serial out.
- R6: On Capture-DR, each analog D bit loads its comparator result and C, B1, B2 and the bus-interface bits load 0. The digital input cell loads `dig_pin` and the digital output cell loads `core_dout`. Update latches change only on the clock leaving Update-DR with the chain selected; they hold through capture, shift, pause and BYPASS scans.
- R7: In mission mode every analog cell enables only its core switch, whatever its latched word holds.
- R8: In isolating test mode the core switch is off and B1 and B2 drive the bus 1 and bus 2 switches. With C=1, D selects the high reference (D=1) or the low reference (D=0). With C=0, D=1 enables the ground reference. At most one reference switch is ever on.
- R9: In probing test mode the core switch is on. With D=0 and C=0, B1 and B2 add the bus 1 and bus 2 switches; any other word leaves only the core switch on.
- R10: `tbic_sw` equals the latched bus-interface word in both test modes and is 0 in mission mode. Bit 0 is AT1-AB1, bit 1 AT2-AB2, bit 2 AT1-AB2 and bit 3 AT2-AB1.
- R11: In isolating test mode `core_din` takes the latched digital input cell and `dig_pout` the latched digital output cell. In every other mode both are transparent: `core_din`=`dig_pin` and `dig_pout`=`core_dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out; 0 outside the shift states |
| abm_cmp | input | 2 | Comparator result per analog cell (bit 0 output pin, bit 1 input pin) |
| dig_pin | input | 1 | Level at the digital input pin |
| core_dout | input | 1 | Inverter output from the core |
| core_din | output | 1 | Value delivered to the core's digital input |
| dig_pout | output | 1 | Value driven on the digital output pin |
| abm_mode | output | 2 | Analog cell mode: 0 mission, 1 isolating test, 2 probing test |
| abm_sw | output | 12 | Six enables per analog cell, cell k at bits 6k+5..6k: core, high ref, low ref, ground ref, bus 1, bus 2 from low to high |
| tbic_sw | output | 4 | Bus-interface switch enables |

## Verification
The bench builds the block with its default parameters: two analog cells, a four-bit bus-interface word and an eight-bit instruction, so the chain is fourteen bits long. At that size random fourteen-bit words, random opcodes and random comparator and pin levels visit all sixteen values of each analog control word under all three modes. Directed scans cover the high-reference pattern, a scan that pauses in the middle, latches holding through a BYPASS scan, an opcode outside the defined set, and a reset driven by `tms` alone from the middle of a shift.

// File: rtl/mxbs_pkg.sv
package mxbs_pkg;

  typedef enum logic [3:0] {
    TS_TLR, TS_RTI, TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR,
    TS_UPD_DR, TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    MODE_MISSION = 2'd0,
    MODE_ISOLATE = 2'd1,
    MODE_PROBE   = 2'd2
  } abm_mode_e;

  localparam int ABM_W  = 4;
  localparam int SW_N   = 6;
  localparam int SW_CORE = 0;
  localparam int SW_VH   = 1;
  localparam int SW_VL   = 2;
  localparam int SW_VG   = 3;
  localparam int SW_AB1  = 4;
  localparam int SW_AB2  = 5;

  // word = {D, C, B1, B2}
  function automatic logic [SW_N-1:0] abm_switches(input abm_mode_e m, input logic [ABM_W-1:0] word);
    logic d, c, b1, b2;
    logic [SW_N-1:0] sw;
    {d, c, b1, b2} = word;
    sw = '0;
    case (m)
      MODE_ISOLATE: begin
        sw[SW_VH]  = c & d;
        sw[SW_VL]  = c & ~d;
        sw[SW_VG]  = ~c & d;
        sw[SW_AB1] = b1;
        sw[SW_AB2] = b2;
      end
      MODE_PROBE: begin
        sw[SW_CORE] = 1'b1;
        sw[SW_AB1]  = ~d & ~c & b1;
        sw[SW_AB2]  = ~d & ~c & b2;
      end
      default: sw[SW_CORE] = 1'b1;
    endcase
    return sw;
  endfunction

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    case (s)
      TS_TLR:    return tms ? TS_TLR    : TS_RTI;
      TS_RTI:    return tms ? TS_SEL_DR : TS_RTI;
      TS_SEL_DR: return tms ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: return tms ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  return tms ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: return tms ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: return tms ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: return tms ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: return tms ? TS_SEL_DR : TS_RTI;
      TS_SEL_IR: return tms ? TS_TLR    : TS_CAP_IR;
      TS_CAP_IR: return tms ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  return tms ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: return tms ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: return tms ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: return tms ? TS_UPD_IR : TS_SH_IR;
      default:   return tms ? TS_SEL_DR : TS_RTI;
    endcase
  endfunction

endpackage

// File: rtl/mxbs_tap_fsm.sv
module mxbs_tap_fsm
  import mxbs_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state_q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state_q <= TS_TLR;
    else         state_q <= tap_next(state_q, tms);
  end

endmodule

// File: rtl/mxbs_ir.sv
module mxbs_ir
  import mxbs_pkg::*;
#(
  parameter int             IR_W       = 8,
  parameter logic [IR_W-1:0] OP_EXTEST = 8'h00,
  parameter logic [IR_W-1:0] OP_PROBE  = 8'h01,
  parameter logic [IR_W-1:0] OP_SAMPLE = 8'h02,
  parameter logic [IR_W-1:0] OP_BYPASS = 8'hFF
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so,
  output abm_mode_e       mode,
  output logic            sel_bsr
);

  localparam logic [IR_W-1:0] IR_CAPTURE = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sh <= IR_CAPTURE;
      ir_q  <= OP_BYPASS;
    end else begin
      case (state)
        TS_TLR:    ir_q  <= OP_BYPASS;
        TS_CAP_IR: ir_sh <= IR_CAPTURE;
        TS_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        TS_UPD_IR: ir_q  <= ir_sh;
        default: ;
      endcase
    end
  end

  assign ir_so = ir_sh[0];

  always_comb begin
    mode    = MODE_MISSION;
    sel_bsr = 1'b0;
    if (ir_q == OP_EXTEST) begin
      mode    = MODE_ISOLATE;
      sel_bsr = 1'b1;
    end else if (ir_q == OP_PROBE) begin
      mode    = MODE_PROBE;
      sel_bsr = 1'b1;
    end else if (ir_q == OP_SAMPLE) begin
      sel_bsr = 1'b1;
    end
  end

endmodule

// File: rtl/mxbs_scan_reg.sv
module mxbs_scan_reg #(
  parameter int W = 14
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         clr,
  input  logic         cap_en,
  input  logic         sh_en,
  input  logic         upd_en,
  input  logic         tdi,
  input  logic [W-1:0] cap_val,
  output logic         so,
  output logic [W-1:0] lat_q
);

  logic [W-1:0] sh_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sh_q  <= '0;
      lat_q <= '0;
    end else if (clr) begin
      sh_q  <= '0;
      lat_q <= '0;
    end else begin
      if (cap_en)     sh_q <= cap_val;
      else if (sh_en) sh_q <= {tdi, sh_q[W-1:1]};
      if (upd_en)     lat_q <= sh_q;
    end
  end

  assign so = sh_q[0];

endmodule

// File: rtl/mxbs_ctrl.sv
module mxbs_ctrl
  import mxbs_pkg::*;
#(
  parameter int NUM_ABM = 2,
  parameter int TBIC_W  = 4,
  parameter int IR_W    = 8
) (
  input  logic                    tck,
  input  logic                    trst_n,
  input  logic                    tms,
  input  logic                    tdi,
  output logic                    tdo,
  input  logic [NUM_ABM-1:0]      abm_cmp,
  input  logic                    dig_pin,
  input  logic                    core_dout,
  output logic                    core_din,
  output logic                    dig_pout,
  output logic [1:0]              abm_mode,
  output logic [NUM_ABM*SW_N-1:0] abm_sw,
  output logic [TBIC_W-1:0]       tbic_sw
);

  localparam int DBM_W     = 2;
  localparam int DBM_OUT   = 0;
  localparam int DBM_IN    = 1;
  localparam int ABM_BASE  = DBM_W;
  localparam int TBIC_BASE = ABM_BASE + NUM_ABM * ABM_W;
  localparam int BSR_W     = TBIC_BASE + TBIC_W;

  tap_state_e      state;
  abm_mode_e       mode;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, sel_bsr;
  logic            bsr_so, byp_q;
  logic [BSR_W-1:0] cap_vec, bsr_lat;

  // named events for the checker
  logic in_tlr, cap_dr_evt, sh_dr_evt, upd_dr_evt;
  assign in_tlr     = (state == TS_TLR);
  assign cap_dr_evt = (state == TS_CAP_DR) && sel_bsr;
  assign sh_dr_evt  = (state == TS_SH_DR)  && sel_bsr;
  assign upd_dr_evt = (state == TS_UPD_DR) && sel_bsr;

  mxbs_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state_q(state)
  );

  mxbs_ir #(.IR_W(IR_W)) u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state),
    .ir_q(ir_q), .ir_so(ir_so), .mode(mode), .sel_bsr(sel_bsr)
  );

  always_comb begin
    cap_vec          = '0;
    cap_vec[DBM_OUT] = core_dout;
    cap_vec[DBM_IN]  = dig_pin;
    for (int k = 0; k < NUM_ABM; k++)
      cap_vec[ABM_BASE + k*ABM_W + ABM_W-1] = abm_cmp[k];
  end

  mxbs_scan_reg #(.W(BSR_W)) u_bsr (
    .tck(tck), .trst_n(trst_n), .clr(in_tlr),
    .cap_en(cap_dr_evt), .sh_en(sh_dr_evt), .upd_en(upd_dr_evt),
    .tdi(tdi), .cap_val(cap_vec), .so(bsr_so), .lat_q(bsr_lat)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                  byp_q <= 1'b0;
    else if (state == TS_CAP_DR)  byp_q <= 1'b0;
    else if (state == TS_SH_DR)   byp_q <= tdi;
  end

  always_comb begin
    case (state)
      TS_SH_IR: tdo = ir_so;
      TS_SH_DR: tdo = sel_bsr ? bsr_so : byp_q;
      default:  tdo = 1'b0;
    endcase
  end

  for (genvar k = 0; k < NUM_ABM; k++) begin : g_abm
    assign abm_sw[k*SW_N +: SW_N] = abm_switches(mode, bsr_lat[ABM_BASE + k*ABM_W +: ABM_W]);
  end

  assign abm_mode = mode;
  assign tbic_sw  = (mode == MODE_MISSION) ? '0 : bsr_lat[TBIC_BASE +: TBIC_W];
  assign core_din = (mode == MODE_ISOLATE) ? bsr_lat[DBM_IN]  : dig_pin;
  assign dig_pout = (mode == MODE_ISOLATE) ? bsr_lat[DBM_OUT] : core_dout;

endmodule

// File: rtl/mxbs_ctrl_chk.sv
module mxbs_ctrl_chk #(
  parameter int NUM_ABM = 2,
  parameter int TBIC_W  = 4,
  parameter int IR_W    = 8
) (
  input logic                  tck,
  input logic                  trst_n,
  input logic                  in_tlr,
  input logic [IR_W-1:0]       ir_q,
  input logic [1:0]            abm_mode,
  input logic [NUM_ABM*6-1:0]  abm_sw,
  input logic [TBIC_W-1:0]     tbic_sw,
  input logic                  dig_pin,
  input logic                  core_din,
  input logic                  core_dout,
  input logic                  dig_pout
);

  p_tlr_bypass_r2: assert property (@(posedge tck) disable iff (!trst_n)
    in_tlr |=> (ir_q == {IR_W{1'b1}}));

  p_mode_legal_r4: assert property (@(posedge tck) disable iff (!trst_n)
    abm_mode != 2'd3);

  p_tbic_open_r10: assert property (@(posedge tck) disable iff (!trst_n)
    (abm_mode == 2'd0) |-> (tbic_sw == '0));

  p_dbm_transparent_r11: assert property (@(posedge tck) disable iff (!trst_n)
    (abm_mode != 2'd1) |-> (core_din == dig_pin && dig_pout == core_dout));

  for (genvar k = 0; k < NUM_ABM; k++) begin : g_chk
    logic [5:0] s;
    assign s = abm_sw[k*6 +: 6];

    p_mission_core_r7: assert property (@(posedge tck) disable iff (!trst_n)
      (abm_mode == 2'd0) |-> (s == 6'b000001));

    p_isolate_core_off_r8: assert property (@(posedge tck) disable iff (!trst_n)
      (abm_mode == 2'd1) |-> !s[0]);

    p_one_source_r8: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0(s[3:1]));

    p_probe_core_r9: assert property (@(posedge tck) disable iff (!trst_n)
      (abm_mode == 2'd2) |-> (s[0] && s[3:1] == 3'b000));
  end

endmodule

bind mxbs_ctrl mxbs_ctrl_chk #(.NUM_ABM(NUM_ABM), .TBIC_W(TBIC_W), .IR_W(IR_W)) u_chk (
  .tck(tck), .trst_n(trst_n), .in_tlr(in_tlr), .ir_q(ir_q), .abm_mode(abm_mode),
  .abm_sw(abm_sw), .tbic_sw(tbic_sw), .dig_pin(dig_pin), .core_din(core_din),
  .core_dout(core_dout), .dig_pout(dig_pout)
);

// File: tb/mxbs_ctrl_bench.sv
module mxbs_ctrl_bench;

  logic        tck = 1'b0;
  logic        trst_n = 1'b0;
  logic        tms = 1'b1;
  logic        tdi = 1'b0;
  logic        tdo;
  logic [1:0]  abm_cmp = 2'b00;
  logic        dig_pin = 1'b0;
  logic        core_dout = 1'b0;
  logic        core_din, dig_pout;
  logic [1:0]  abm_mode;
  logic [11:0] abm_sw;
  logic [3:0]  tbic_sw;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0]  e_ir;
  logic [13:0] e_lat;

  always #2 tck = ~tck;

  mxbs_ctrl u_mxbs_ctrl (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .abm_cmp(abm_cmp), .dig_pin(dig_pin), .core_dout(core_dout),
    .core_din(core_din), .dig_pout(dig_pout), .abm_mode(abm_mode),
    .abm_sw(abm_sw), .tbic_sw(tbic_sw)
  );

  // ---------------- expected-value functions ----------------
  function automatic logic [1:0] e_mode(input logic [7:0] op);
    if (op == 8'h00) return 2'd1;
    if (op == 8'h01) return 2'd2;
    return 2'd0;
  endfunction

  function automatic bit e_sel(input logic [7:0] op);
    return (op == 8'h00) || (op == 8'h01) || (op == 8'h02);
  endfunction

  // bit 0 core, 1 vh, 2 vl, 3 vg, 4 ab1, 5 ab2 ; w = {D,C,B1,B2}
  function automatic logic [5:0] e_abm(input logic [1:0] m, input logic [3:0] w);
    logic [5:0] r;
    r = 6'b000000;
    if (m == 2'd1) begin
      if (w[2]) begin
        if (w[3]) r[1] = 1'b1; else r[2] = 1'b1;
      end else if (w[3]) r[3] = 1'b1;
      r[4] = w[1];
      r[5] = w[0];
    end else if (m == 2'd2) begin
      r = (w[3:2] == 2'b00) ? {w[0], w[1], 4'b0001} : 6'b000001;
    end else begin
      r = 6'b000001;
    end
    return r;
  endfunction

  function automatic logic [13:0] e_cap();
    return {4'b0000, abm_cmp[1], 3'b000, abm_cmp[0], 3'b000, dig_pin, core_dout};
  endfunction

  // ---------------- check and drive tasks ----------------
  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic step(input logic tms_v, input logic tdi_v, output logic o);
    @(negedge tck);
    o   = tdo;
    tms = tms_v;
    tdi = tdi_v;
    @(posedge tck);
  endtask

  task automatic check_outputs();
    logic [1:0]  m;
    logic [11:0] xs;
    string rq;
    #1;
    m  = e_mode(e_ir);
    rq = (m == 2'd0) ? "R7" : ((m == 2'd1) ? "R8" : "R9");
    xs = {e_abm(m, e_lat[9:6]), e_abm(m, e_lat[5:2])};
    chk(abm_mode == m, "R4", "abm_mode", 64'(abm_mode), 64'(m));
    chk(abm_sw == xs, rq, "abm_sw", 64'(abm_sw), 64'(xs));
    chk(tbic_sw == ((m == 2'd0) ? 4'h0 : e_lat[13:10]), "R10", "tbic_sw",
        64'(tbic_sw), 64'((m == 2'd0) ? 4'h0 : e_lat[13:10]));
    chk(core_din == ((m == 2'd1) ? e_lat[1] : dig_pin), "R11", "core_din",
        64'(core_din), 64'((m == 2'd1) ? e_lat[1] : dig_pin));
    chk(dig_pout == ((m == 2'd1) ? e_lat[0] : core_dout), "R11", "dig_pout",
        64'(dig_pout), 64'((m == 2'd1) ? e_lat[0] : core_dout));
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic ir_scan(input logic [7:0] op);
    logic o;
    logic [7:0] got;
    step(1, 0, o); step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 8; i++) begin
      step(i == 7, op[i], o);
      got[i] = o;
    end
    step(1, 0, o); step(0, 0, o);
    chk(got == 8'h01, "R3", "IR capture", 64'(got), 64'h01);
    e_ir = op;
  endtask

  task automatic dr_scan(input logic [13:0] data);
    logic o;
    logic [13:0] got, xc;
    xc = e_cap();
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 14; i++) begin
      step(i == 13, data[i], o);
      got[i] = o;
    end
    check_outputs();   // in Exit1-DR: latches still hold (R6)
    step(1, 0, o); step(0, 0, o);
    if (e_sel(e_ir)) begin
      chk(got == xc, "R6", "DR capture", 64'(got), 64'(xc));
      e_lat = data;
    end else begin
      chk(got == {data[12:0], 1'b0}, "R4", "bypass delay", 64'(got), 64'({data[12:0], 1'b0}));
    end
  endtask

  task automatic set_pins(input logic [1:0] c, input logic dp, input logic cd);
    @(negedge tck);
    abm_cmp = c; dig_pin = dp; core_dout = cd;
  endtask

  // ---------------- main sequence ----------------
  initial begin
    logic o;
    logic [13:0] d;
    logic [7:0] op;
    void'($urandom(32'h0000_4A1D));
    e_ir = 8'hFF;
    e_lat = '0;
    repeat (3) @(posedge tck);
    @(negedge tck) trst_n = 1'b1;
    check_outputs();                              // R2 reset state
    chk(tdo == 1'b0, "R2", "tdo idle", 64'(tdo), 0);
    step(0, 0, o);

    // R2: latches clear after reset -> EXTEST shows all switches off
    ir_scan(8'h00);
    check_outputs();
    chk(abm_sw == 12'h000, "R2", "latches zero under test", 64'(abm_sw), 0);

    // R8: D=C=B1=B2=1 -> vh + ab1 + ab2 ; R5 positions
    set_pins(2'b10, 1'b1, 1'b0);
    dr_scan(14'b1010_1111_1111_10);
    check_outputs();
    chk(abm_sw == 12'b110010_110010, "R8", "high ref pattern", 64'(abm_sw), 64'hCB2);
    chk(tbic_sw == 4'b1010, "R5", "bus word position", 64'(tbic_sw), 64'hA);
    chk(dig_pout == 1'b0 && core_din == 1'b1, "R5", "digital cell position",
        64'({dig_pout, core_din}), 64'h1);

    // R9: probe with D=1 -> core only ; D=C=0 B=11 -> core + buses
    ir_scan(8'h01);
    dr_scan(14'b0001_1000_0011_00);
    check_outputs();
    chk(abm_sw == 12'b000001_110001, "R9", "probe words", 64'(abm_sw), 64'h071);

    // R6: latches hold through a BYPASS scan
    ir_scan(8'hFF);
    dr_scan(14'h3FFF);
    ir_scan(8'h00);
    check_outputs();
    chk(tbic_sw == 4'b0001, "R6", "held bus word", 64'(tbic_sw), 64'h1);

    // R4: undefined opcode acts as bypass
    ir_scan(8'h5A);
    dr_scan(14'h1234);
    check_outputs();

    // R1: scan through Pause-DR under EXTEST
    ir_scan(8'h00);
    d = 14'b0110_0101_1100_01;
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 7; i++) step(i == 6, d[i], o);
    step(0, 0, o); step(0, 0, o); step(1, 0, o); step(0, 0, o);
    for (int i = 7; i < 14; i++) step(i == 13, d[i], o);
    step(1, 0, o); step(0, 0, o);
    e_lat = d;
    check_outputs();
    chk(tbic_sw == 4'b0110, "R1", "paused scan result", 64'(tbic_sw), 64'h6);

    // R1/R2: tms-only reset from Shift-DR
    step(1, 0, o); step(0, 0, o); step(0, 0, o);
    for (int i = 0; i < 6; i++) step(1, 1, o);
    step(0, 0, o);
    e_ir = 8'hFF;
    e_lat = '0;
    check_outputs();
    chk(abm_mode == 2'd0, "R1", "mission after tms reset", 64'(abm_mode), 0);
    ir_scan(8'h00);
    check_outputs();
    chk(abm_sw == 12'h000 && tbic_sw == 4'h0, "R2", "latches cleared by tms reset",
        64'({abm_sw, tbic_sw}), 0);

    // random mix
    for (int it = 0; it < 60; it++) begin
      case ($urandom_range(0, 4))
        0: op = 8'h00;
        1: op = 8'h01;
        2: op = 8'h02;
        3: op = 8'hFF;
        default: op = 8'($urandom);
      endcase
      set_pins(2'($urandom), 1'($urandom), 1'($urandom));
      ir_scan(op);
      check_outputs();
      dr_scan(14'($urandom));
      check_outputs();
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule